// File: doc/BRIEF.md
# Rational-Ratio Clock Enable Generator

This block turns a fast system clock into a slower event stream whose average rate is the input rate multiplied by a rational fraction X/Y. The numerator and denominator are loaded at run time. The internal phase word counts modulo Y rather than modulo a power of two, so a ratio such as 4/17 is met exactly and not through a rounded binary fraction. Every output event is aligned to an input clock edge. The spacing between events can therefore vary by up to one input period.

Three operating modes are selected at load time. Pulse mode gives a single-cycle enable on every wrap of the phase word. Half-period mode compares the phase against half the modulus and inverts a square-wave output at each crossing, which gives a near-even duty cycle. Carry-correction mode keeps a plain power-of-two phase word and adds an extra amount (2^W minus Y) on the cycle after each carry, so that the long-run rate is still X/Y. If a configuration is out of range, the outputs are held at zero.

Top module: `fracclk_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `tick_o`, `sq_o` and `phase_o` to zero and clears the stored configuration, so the block is idle until the first load.
- R2: A cycle with `cfg_load` high captures `cfg_inc` (X), `cfg_mod` (Y) and `cfg_mode`, and clears the phase, the square output and the tick at that edge. Stepping starts at the following edge, so `phase_o` equals X one cycle after the load in pulse mode.
- R3: Pulse mode (`cfg_mode` = 0): at every edge the phase becomes (phase + X) mod Y, and `tick_o` is high for exactly the cycles that follow an edge where phase + X reached Y or more.
- R4: In pulse mode, over the Y edges that follow a load, `tick_o` is high in exactly X cycles and `phase_o` is back at 0 after edge Y (for example, 4 ticks in 17 cycles for 4/17).
- R5: In pulse mode, the distance between consecutive ticks is always floor(Y/X) or ceil(Y/X) cycles, which is a jitter of at most one input period.
- R6: Half-period mode (`cfg_mode` = 1), with H = floor(Y/2): when the phase is at least H, the next phase is phase + X - H, `sq_o` inverts and `tick_o` is high. Otherwise the next phase is phase + X, `sq_o` holds and `tick_o` is low.
- R7: In half-period mode with Y even, `sq_o` changes exactly 2X times over edges Y+1 to 2Y after a load (6 times for 3/8).
- R8: Carry-correction mode (`cfg_mode` = 2): the phase is a W-bit word. Each edge adds X, plus (2^W - Y) when the previous edge produced a carry out of bit W-1. `tick_o` is high in the cycle after each carry.
- R9: In carry-correction mode, edges Y+1 to 2Y after a load contain exactly X ticks (12 ticks for X=12, Y=1021, W=10).
- R10: A configuration is rejected, and `tick_o`, `sq_o` and `phase_o` stay at zero until the next load, if any of these holds: X >= Y in pulse or carry-correction mode, X >= floor(Y/2) in half-period mode, or `cfg_mode` = 3.
- R11: `sq_o` stays at 0 in pulse mode and in carry-correction mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture the configuration and restart the phase |
| cfg_mode | input | 2 | 0 pulse, 1 half-period, 2 carry-correction, 3 rejected |
| cfg_inc | input | ACC_W | Increment X |
| cfg_mod | input | ACC_W | Modulus Y |
| tick_o | output | 1 | One-cycle enable on each wrap |
| sq_o | output | 1 | Square-wave output in half-period mode |
| phase_o | output | ACC_W | Current phase word |

## Verification
The hardest behaviour to reach is the steady-state rate in carry-correction mode. The phase word does not return to its start value after the first Y cycles; the count of exactly X ticks per Y cycles only settles once the correction cycle has repeated. The stimulus therefore runs 12/1021 for two full periods and counts ticks only in the second one. Half-period mode is handled the same way with 3/8, and a mid-run reload confirms that the phase restarts from zero at the load edge. A per-cycle reference model feeds a scoreboard with the expected tick, square and phase for every mode, including rejected configurations.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [1:0] {
    FCG_PULSE = 2'd0,
    FCG_HALF  = 2'd1,
    FCG_CORR  = 2'd2,
    FCG_BAD   = 2'd3
  } fcg_mode_e;
endpackage

// File: rtl/fcg_cfg.sv
// Configuration holding registers and the range check on a load.
module fcg_cfg
  import fcg_pkg::*;
#(
  parameter int W        = 10,
  parameter bit HAS_CORR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    mode_in,
  input  logic [W-1:0]  inc_in,
  input  logic [W-1:0]  mod_in,
  output fcg_mode_e     mode_q,
  output logic [W-1:0]  inc_q,
  output logic [W-1:0]  mod_q,
  output logic [W-1:0]  half_q,
  output logic [W-1:0]  comp_q,
  output logic          valid_q
);
  fcg_mode_e    mode_cast;
  logic [W-1:0] half_in;
  logic [W:0]   comp_full;
  logic         corr_ok;
  logic         ok_now;

  assign mode_cast = fcg_mode_e'(mode_in);
  assign half_in   = mod_in >> 1;
  assign comp_full = {1'b1, {W{1'b0}}} - {1'b0, mod_in};

  generate
    if (HAS_CORR) begin : g_corr_on
      assign corr_ok = (inc_in < mod_in);
    end else begin : g_corr_off
      assign corr_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    case (mode_cast)
      FCG_PULSE: ok_now = (inc_in < mod_in);
      FCG_HALF:  ok_now = (inc_in < half_in);
      FCG_CORR:  ok_now = corr_ok;
      default:   ok_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= FCG_PULSE;
      inc_q   <= '0;
      mod_q   <= '0;
      half_q  <= '0;
      comp_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      mode_q  <= mode_cast;
      inc_q   <= inc_in;
      mod_q   <= mod_in;
      half_q  <= half_in;
      comp_q  <= comp_full[W-1:0];
      valid_q <= ok_now;
    end
  end
endmodule

// File: rtl/fcg_step.sv
// Next-phase arithmetic for the three stepping rules.
module fcg_step
  import fcg_pkg::*;
#(
  parameter int W        = 10,
  parameter bit HAS_CORR = 1'b1
) (
  input  fcg_mode_e    mode,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] modv,
  input  logic [W-1:0] half,
  input  logic [W-1:0] comp,
  input  logic [W-1:0] acc,
  input  logic         cor,
  output logic [W-1:0] acc_nx,
  output logic         cor_nx,
  output logic         wrap
);
  logic [W:0]   sum;
  logic [W:0]   adj;
  logic [W-1:0] corr_add;

  generate
    if (HAS_CORR) begin : g_corr_path
      assign corr_add = cor ? comp : '0;
    end else begin : g_no_corr_path
      assign corr_add = '0;
    end
  endgenerate

  assign sum = {1'b0, acc} + {1'b0, inc};

  always_comb begin
    adj    = '0;
    acc_nx = '0;
    cor_nx = 1'b0;
    wrap   = 1'b0;
    case (mode)
      FCG_PULSE: begin
        if (sum >= {1'b0, modv}) begin
          adj    = sum - {1'b0, modv};
          acc_nx = adj[W-1:0];
          wrap   = 1'b1;
        end else begin
          acc_nx = sum[W-1:0];
        end
      end
      FCG_HALF: begin
        if (acc >= half) begin
          adj    = sum - {1'b0, half};
          acc_nx = adj[W-1:0];
          wrap   = 1'b1;
        end else begin
          acc_nx = sum[W-1:0];
        end
      end
      FCG_CORR: begin
        adj    = sum + {1'b0, corr_add};
        acc_nx = adj[W-1:0];
        wrap   = adj[W];
        cor_nx = adj[W];
      end
      default: begin
        acc_nx = '0;
      end
    endcase
  end
endmodule

// File: rtl/fcg_core.sv
// Phase, carry, tick and square-wave registers.
module fcg_core
  import fcg_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         valid,
  input  fcg_mode_e    mode,
  input  logic [W-1:0] inc,
  input  logic [W-1:0] modv,
  input  logic [W-1:0] acc_nx,
  input  logic         cor_nx,
  input  logic         wrap,
  output logic [W-1:0] acc_q,
  output logic         cor_q,
  output logic         tick_q,
  output logic         sq_q
);
  always_ff @(posedge clk) begin
    if (rst || load || !valid) begin
      acc_q  <= '0;
      cor_q  <= 1'b0;
      tick_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      acc_q  <= acc_nx;
      cor_q  <= cor_nx;
      tick_q <= wrap;
      if (mode == FCG_HALF && wrap) begin
        sq_q <= ~sq_q;
      end
    end
  end

  // R3
  pulse_range_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && mode == FCG_PULSE) |-> (acc_q < modv));

  // R3
  pulse_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && mode == FCG_PULSE && tick_q) |-> (acc_q < inc));

  // R6
  half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && mode == FCG_HALF && !$past(load)) |->
      ((sq_q != $past(sq_q)) == tick_q));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid) |-> (!tick_q && !sq_q && acc_q == '0));

  // R11
  sq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != FCG_HALF) |-> !sq_q);
endmodule

// File: rtl/fracclk_gen.sv
module fracclk_gen
  import fcg_pkg::*;
#(
  parameter int ACC_W    = 10,
  parameter bit HAS_CORR = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [1:0]       cfg_mode,
  input  logic [ACC_W-1:0] cfg_inc,
  input  logic [ACC_W-1:0] cfg_mod,
  output logic             tick_o,
  output logic             sq_o,
  output logic [ACC_W-1:0] phase_o
);
  fcg_mode_e        mode_q;
  logic [ACC_W-1:0] inc_q, mod_q, half_q, comp_q;
  logic             valid_q;
  logic [ACC_W-1:0] acc_q, acc_nx;
  logic             cor_q, cor_nx, wrap;
  logic             tick_q, sq_q;

  fcg_cfg #(.W(ACC_W), .HAS_CORR(HAS_CORR)) cfg_i (
    .clk(clk), .rst(rst), .load(cfg_load),
    .mode_in(cfg_mode), .inc_in(cfg_inc), .mod_in(cfg_mod),
    .mode_q(mode_q), .inc_q(inc_q), .mod_q(mod_q),
    .half_q(half_q), .comp_q(comp_q), .valid_q(valid_q)
  );

  fcg_step #(.W(ACC_W), .HAS_CORR(HAS_CORR)) step_i (
    .mode(mode_q), .inc(inc_q), .modv(mod_q), .half(half_q),
    .comp(comp_q), .acc(acc_q), .cor(cor_q),
    .acc_nx(acc_nx), .cor_nx(cor_nx), .wrap(wrap)
  );

  fcg_core #(.W(ACC_W)) core_i (
    .clk(clk), .rst(rst), .load(cfg_load), .valid(valid_q),
    .mode(mode_q), .inc(inc_q), .modv(mod_q),
    .acc_nx(acc_nx), .cor_nx(cor_nx), .wrap(wrap),
    .acc_q(acc_q), .cor_q(cor_q), .tick_q(tick_q), .sq_q(sq_q)
  );

  assign tick_o  = tick_q;
  assign sq_o    = sq_q;
  assign phase_o = acc_q;
endmodule

// File: tb/fracclk_gen_tb_top.sv
module fracclk_gen_tb_top;
  localparam int W = 10;

  typedef struct packed {
    logic         tick;
    logic         sq;
    logic [W-1:0] phase;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_load;
  logic [1:0]   cfg_mode;
  logic [W-1:0] cfg_inc;
  logic [W-1:0] cfg_mod;
  logic         tick_o;
  logic         sq_o;
  logic [W-1:0] phase_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";
  exp_t  sb_q[$];

  // model state
  int m_inc = 0, m_mod = 0, m_mode = 0, m_acc = 0;
  bit m_valid = 0, m_cor = 0, m_tick = 0, m_sq = 0;

  always #10 clk = ~clk;

  fracclk_gen #(.ACC_W(W)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_inc(cfg_inc), .cfg_mod(cfg_mod),
    .tick_o(tick_o), .sq_o(sq_o), .phase_o(phase_o)
  );

  function automatic bit cfg_ok(int x, int y, int md);
    case (md)
      0: return x < y;
      1: return x < (y / 2);
      2: return x < y;
      default: return 1'b0;
    endcase
  endfunction

  // driver side: per-cycle reference model pushes expected outputs
  always @(posedge clk) begin
    int s;
    exp_t e;
    if (rst) begin
      m_inc = 0; m_mod = 0; m_mode = 0; m_valid = 0;
      m_acc = 0; m_cor = 0; m_tick = 0; m_sq = 0;
    end else if (cfg_load) begin
      m_inc = int'(cfg_inc); m_mod = int'(cfg_mod); m_mode = int'(cfg_mode);
      m_valid = cfg_ok(m_inc, m_mod, m_mode);
      m_acc = 0; m_cor = 0; m_tick = 0; m_sq = 0;
    end else if (!m_valid) begin
      m_acc = 0; m_cor = 0; m_tick = 0; m_sq = 0;
    end else begin
      case (m_mode)
        0: begin
          s = m_acc + m_inc;
          m_tick = (s >= m_mod);
          m_acc  = m_tick ? s - m_mod : s;
        end
        1: begin
          if (m_acc >= m_mod / 2) begin
            m_acc = m_acc + m_inc - m_mod / 2; m_tick = 1; m_sq = !m_sq;
          end else begin
            m_acc = m_acc + m_inc; m_tick = 0;
          end
        end
        default: begin
          s = m_acc + m_inc + (m_cor ? ((1 << W) - m_mod) : 0);
          m_tick = (s >= (1 << W));
          m_acc  = s % (1 << W);
          m_cor  = m_tick;
        end
      endcase
    end
    e.tick = m_tick; e.sq = m_sq; e.phase = m_acc[W-1:0];
    sb_q.push_back(e);
  end

  // monitor side: compare away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (!done && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_chk++;
      if (tick_o !== e.tick || sq_o !== e.sq || phase_o !== e.phase) begin
        n_fail++;
        $display("FAIL %s scoreboard: got tick=%0b sq=%0b phase=%0d expected tick=%0b sq=%0b phase=%0d",
                 cur_req, tick_o, sq_o, phase_o, e.tick, e.sq, e.phase);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic ld(input int x, input int y, input int md);
    @(negedge clk);
    cfg_inc = x[W-1:0]; cfg_mod = y[W-1:0]; cfg_mode = md[1:0]; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // run n cycles, counting ticks and square changes
  task automatic run(input int n, output int ticks, output int flips);
    logic prev;
    ticks = 0; flips = 0; prev = sq_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_o) ticks++;
      if (sq_o != prev) flips++;
      prev = sq_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t, f, last, gap, lo_gap, hi_gap, sq_hi;
    rst = 1'b1; cfg_load = 1'b0; cfg_mode = 2'd0; cfg_inc = '0; cfg_mod = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tick_o == 1'b0, "R1 tick", int'(tick_o), 0);
    chk(sq_o == 1'b0, "R1 sq", int'(sq_o), 0);
    chk(phase_o == '0, "R1 phase", int'(phase_o), 0);
    rst = 1'b0;
    run(6, t, f);
    chk(t == 0 && phase_o == '0, "R1 idle before load", t, 0);

    // R2/R4/R5/R11 pulse 4/17
    cur_req = "R3";
    ld(4, 17, 0);
    chk(phase_o == '0 && tick_o == 1'b0, "R2 cleared at load", int'(phase_o), 0);
    @(negedge clk);
    chk(phase_o == 10'd4, "R2 first step", int'(phase_o), 4);
    t = 0; sq_hi = 0;
    if (tick_o) t++;
    for (int i = 1; i < 17; i++) begin
      @(negedge clk);
      if (tick_o) t++;
      if (sq_o) sq_hi++;
    end
    chk(t == 4, "R4 ticks per 17", t, 4);
    chk(phase_o == '0, "R4 phase returns", int'(phase_o), 0);
    last = -1; lo_gap = 1000; hi_gap = 0;
    for (int i = 0; i < 68; i++) begin
      @(negedge clk);
      if (sq_o) sq_hi++;
      if (tick_o) begin
        if (last >= 0) begin
          gap = i - last;
          if (gap < lo_gap) lo_gap = gap;
          if (gap > hi_gap) hi_gap = gap;
        end
        last = i;
      end
    end
    chk(lo_gap >= 4, "R5 min spacing", lo_gap, 4);
    chk(hi_gap <= 5, "R5 max spacing", hi_gap, 5);
    chk(sq_hi == 0, "R11 sq quiet in pulse", sq_hi, 0);

    // R2 mid-run reload
    ld(3, 10, 0);
    chk(phase_o == '0, "R2 reload clears", int'(phase_o), 0);
    @(negedge clk);
    chk(phase_o == 10'd3, "R2 reload step", int'(phase_o), 3);

    // R3 dense pulse 5/7
    ld(5, 7, 0);
    run(7, t, f);
    chk(t == 5, "R3 ticks 5/7", t, 5);
    run(21, t, f);

    // R6/R7 half-period 3/8
    cur_req = "R6";
    ld(3, 8, 1);
    run(8, t, f);
    run(8, t, f);
    chk(f == 6, "R7 sq changes per 8", f, 6);
    chk(t == 6, "R6 ticks match toggles", t, 6);
    ld(2, 9, 1);
    run(40, t, f);

    // R8/R9 carry correction 12/1021
    cur_req = "R8";
    ld(12, 1021, 2);
    run(1021, t, f);
    run(1021, t, f);
    chk(t == 12, "R9 ticks in second period", t, 12);
    chk(f == 0, "R11 sq quiet in correction", f, 0);

    // R10 rejected configurations
    cur_req = "R10";
    ld(17, 17, 0);
    run(30, t, f);
    chk(t == 0 && phase_o == '0, "R10 pulse X>=Y", t, 0);
    ld(8, 16, 1);
    run(30, t, f);
    chk(t == 0 && f == 0, "R10 half X>=Y/2", t + f, 0);
    ld(3, 10, 3);
    run(30, t, f);
    chk(t == 0 && phase_o == '0, "R10 mode 3", t, 0);
    ld(5, 0, 2);
    run(10, t, f);
    chk(t == 0, "R10 zero modulus", t, 0);

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule